// File: doc/BRIEF.md
# Edge-Timed Phase Meter for Square-Wave Pairs

This block measures the phase of a transducer response against the drive reference that excites it. Both arrive as digital square waves that have already been squared up from sine waves. The measurement uses only edge timing. A two-state phase-frequency detector is run at the system clock. Its "lead" and "lag" states are timed in clock counts over a programmable number of reference periods. At the end of each such window the block divides the count difference by the window length in clocks and scales the result to hundredths of a degree. It folds the result into a half-turn range on either side of zero and presents it with a one-clock strobe.

Each input goes through its own multi-flop synchronizer, so the two waves may be fully asynchronous to the clock. Only rising edges matter, so the duty cycle and amplitude of either wave have no influence. A restoring divider produces the quotient, one bit per clock. If a window closes while the previous division is still running, that window's result is dropped and counting continues. A window is only shorter than a division when both the window length and the reference period are very short.

Top module: `pfd_phase_meter`

## Requirements
- R1: Each input passes through a two-flop synchronizer before its rising edge is detected. A signal rising edge sets the lead state and a reference rising edge sets the lag state. When both states are set, both clear on the following clock, so two coincident edges give zero phase.
- R2: The first reference rising edge after reset opens the first window. A window closes on every Nth reference rising edge after it opened, where N is `win_len` and a value of 0 acts as 1. Consecutive strobes are therefore exactly N × (reference period in clocks) apart. No strobe appears before reference edges occur.
- R3: Phase in hundredths of a degree is 36000 × (lead clocks − lag clocks) / (window clocks). The magnitude is truncated toward zero, and the result is given as a two's-complement value on `phase_cdeg`.
- R4: A raw result above +18000 has 36000 subtracted from it, and a raw result below −18000 has 36000 added. Every reported value therefore lies in [−18000, +18000].
- R5: The result does not depend on the high time of either square wave, only on the spacing of the rising edges.
- R6: The lead, lag and window-clock counters saturate at 2^CNT_W − 1 and do not wrap. With CNT_W = 10, a 40-clock period, a window of 40 and the reference leading by 30 clocks, the reported phase is +1408.
- R7: After reset, `phase_cdeg` is 0 and `phase_valid` is 0. `phase_valid` is high for exactly one clock per result, and `phase_cdeg` holds its value between strobes.
- R8: A signal that leads the reference by d clocks of a P-clock period gives a positive phase of 36000·d/P. A signal that lags by d clocks gives the negative of that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one count per cycle |
| rst | input | 1 | Synchronous active-high reset |
| sig_sq | input | 1 | Transducer response square wave, asynchronous |
| ref_sq | input | 1 | Drive reference square wave, asynchronous |
| win_len | input | LEN_W | Window length in reference periods (0 acts as 1) |
| phase_cdeg | output | PH_W | Signed phase in hundredths of a degree |
| phase_valid | output | 1 | One-clock strobe when a new phase is presented |

## Verification
A detector state that clears late or sticks shows at the ports as a phase that is off by whole clock counts per period. This appears at the first strobe after the wave pair starts. A window counter that miscounts shows as the wrong spacing between consecutive strobes, measured exactly in clocks. Wrapping counters, a missing fold into the half-turn range or a sign error each give a visibly wrong value at the second strobe of a directed case. Those cases are chosen so that the exact quotient is known in advance.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int unsigned FULL_TURN_CDEG = 36000;
  localparam int unsigned HALF_TURN_CDEG = 18000;
  localparam int unsigned SCALE_W        = 16;
endpackage

// File: rtl/pm_sync_edge.sv
module pm_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], din};
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/pm_pfd.sv
module pm_pfd (
  input  logic clk,
  input  logic rst,
  input  logic sig_rise,
  input  logic ref_rise,
  output logic up_q,
  output logic dn_q
);
  logic clear;
  assign clear = up_q & dn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= clear ? sig_rise : (up_q | sig_rise);
      dn_q <= clear ? ref_rise : (dn_q | ref_rise);
    end
  end

  AST_PFD_BOTH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (up_q && dn_q) |=> !(up_q && dn_q)); // R1
  AST_PFD_UP_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(up_q) |-> $past(sig_rise)); // R1
  AST_PFD_DN_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_q) |-> $past(ref_rise)); // R1
endmodule

// File: rtl/pm_window.sv
module pm_window #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_rise,
  input  logic             up_q,
  input  logic             dn_q,
  input  logic [LEN_W-1:0] win_len,
  output logic             win_done,
  output logic [CNT_W-1:0] cap_up,
  output logic [CNT_W-1:0] cap_dn,
  output logic [CNT_W-1:0] cap_tot
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v, input logic en);
    return (v == CNT_MAX) ? v : v + CNT_W'(en);
  endfunction

  logic             armed;
  logic [LEN_W-1:0] per_cnt;
  logic [LEN_W-1:0] eff_len;
  logic [CNT_W-1:0] acc_up, acc_dn, acc_tot;
  logic [CNT_W-1:0] nxt_up, nxt_dn, nxt_tot;
  logic             last_period, closing;

  assign eff_len     = (win_len == '0) ? LEN_W'(1) : win_len;
  assign last_period = ({1'b0, per_cnt} + (LEN_W+1)'(1)) >= {1'b0, eff_len};
  assign closing     = armed & ref_rise & last_period;
  assign nxt_up      = sat_inc(acc_up, up_q);
  assign nxt_dn      = sat_inc(acc_dn, dn_q);
  assign nxt_tot     = sat_inc(acc_tot, 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      per_cnt  <= '0;
      acc_up   <= '0;
      acc_dn   <= '0;
      acc_tot  <= '0;
      cap_up   <= '0;
      cap_dn   <= '0;
      cap_tot  <= '0;
      win_done <= 1'b0;
    end else begin
      win_done <= closing;
      if (!armed) begin
        armed <= ref_rise;
      end else if (closing) begin
        cap_up  <= nxt_up;
        cap_dn  <= nxt_dn;
        cap_tot <= nxt_tot;
        acc_up  <= '0;
        acc_dn  <= '0;
        acc_tot <= '0;
        per_cnt <= '0;
      end else begin
        acc_up  <= nxt_up;
        acc_dn  <= nxt_dn;
        acc_tot <= nxt_tot;
        if (ref_rise) per_cnt <= per_cnt + LEN_W'(1);
      end
    end
  end

  AST_SAT_HOLD_UP: assert property (@(posedge clk) disable iff (rst)
    (armed && !closing && acc_up == CNT_MAX) |=> (acc_up == CNT_MAX)); // R6
  AST_SAT_HOLD_TOT: assert property (@(posedge clk) disable iff (rst)
    (armed && !closing && acc_tot == CNT_MAX) |=> (acc_tot == CNT_MAX)); // R6
  AST_WIN_ON_REF: assert property (@(posedge clk) disable iff (rst)
    win_done |-> $past(ref_rise)); // R2
  AST_CAP_BOUND: assert property (@(posedge clk) disable iff (rst)
    win_done |-> (cap_up <= cap_tot && cap_dn <= cap_tot)); // R3
endmodule

// File: rtl/pm_divider.sv
module pm_divider #(
  parameter int unsigned NUM_W = 32,
  parameter int unsigned DEN_W = 16,
  parameter int unsigned Q_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [Q_W-1:0]   quot
);
  localparam int unsigned CW = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem, den_q;
  logic [NUM_W-1:0] qr;
  logic [CW-1:0]    cnt;
  logic [DEN_W:0]   trial;
  logic             ge;

  assign trial = {rem, qr[NUM_W-1]};
  assign ge    = trial >= {1'b0, den_q};
  assign quot  = qr[Q_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rem   <= '0;
      den_q <= '0;
      qr    <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          rem   <= '0;
          qr    <= num;
          den_q <= den;
          cnt   <= CW'(NUM_W);
        end
      end else begin
        rem <= ge ? (trial[DEN_W-1:0] - den_q) : trial[DEN_W-1:0];
        qr  <= {qr[NUM_W-2:0], ge};
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_DIV_LOAD: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R3
  AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
    (busy && den_q != '0) |-> (rem < den_q)); // R3
endmodule

// File: rtl/pfd_phase_meter.sv
module pfd_phase_meter
  import pm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned LEN_W       = 8,
  parameter int unsigned PH_W        = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sig_sq,
  input  logic                   ref_sq,
  input  logic [LEN_W-1:0]       win_len,
  output logic signed [PH_W-1:0] phase_cdeg,
  output logic                   phase_valid
);
  localparam int unsigned PROD_W = CNT_W + SCALE_W;
  localparam logic [PH_W-1:0] FULL_T = PH_W'(FULL_TURN_CDEG);
  localparam logic [PH_W-1:0] HALF_T = PH_W'(HALF_TURN_CDEG);

  // channel 0 = signal, channel 1 = reference
  logic [1:0] raw_in, rise_v;
  assign raw_in = {ref_sq, sig_sq};

  for (genvar i = 0; i < 2; i++) begin : g_sync
    pm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (raw_in[i]),
      .rise(rise_v[i])
    );
  end

  logic up_q, dn_q;
  pm_pfd u_pfd (
    .clk     (clk),
    .rst     (rst),
    .sig_rise(rise_v[0]),
    .ref_rise(rise_v[1]),
    .up_q    (up_q),
    .dn_q    (dn_q)
  );

  logic             win_done;
  logic [CNT_W-1:0] cap_up, cap_dn, cap_tot;
  pm_window #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_win (
    .clk     (clk),
    .rst     (rst),
    .ref_rise(rise_v[1]),
    .up_q    (up_q),
    .dn_q    (dn_q),
    .win_len (win_len),
    .win_done(win_done),
    .cap_up  (cap_up),
    .cap_dn  (cap_dn),
    .cap_tot (cap_tot)
  );

  logic              neg_now, neg_q;
  logic [CNT_W-1:0]  mag;
  logic [PROD_W-1:0] num;
  logic              div_start, div_busy, div_done;
  logic [PH_W-1:0]   quot;

  assign neg_now   = cap_dn > cap_up;
  assign mag       = neg_now ? (cap_dn - cap_up) : (cap_up - cap_dn);
  assign num       = PROD_W'(mag) * PROD_W'(FULL_TURN_CDEG);
  assign div_start = win_done & ~div_busy;

  pm_divider #(.NUM_W(PROD_W), .DEN_W(CNT_W), .Q_W(PH_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .start(div_start),
    .num  (num),
    .den  (cap_tot),
    .busy (div_busy),
    .done (div_done),
    .quot (quot)
  );

  // fold into the half-turn range; arithmetic is exact modulo 2^PH_W
  logic            over;
  logic [PH_W-1:0] folded;
  assign over = quot > HALF_T;
  always_comb begin
    unique case ({neg_q, over})
      2'b00:   folded = quot;
      2'b01:   folded = quot - FULL_T;
      2'b10:   folded = '0 - quot;
      default: folded = FULL_T - quot;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      neg_q       <= 1'b0;
      phase_cdeg  <= '0;
      phase_valid <= 1'b0;
    end else begin
      if (div_start) neg_q <= neg_now;
      phase_valid <= div_done;
      if (div_done) phase_cdeg <= $signed(folded);
    end
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    phase_valid |-> (phase_cdeg <= 18000 && phase_cdeg >= -18000)); // R4
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    phase_valid |=> !phase_valid); // R7
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !phase_valid |-> $stable(phase_cdeg)); // R7
endmodule

// File: tb/pfd_phase_meter_test.sv
`timescale 1ns/1ps
module pfd_phase_meter_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sig_sq = 1'b0, ref_sq = 1'b0;
  logic [7:0] win_len = 8'd1;
  logic signed [15:0] ph_a, ph_b;
  logic vld_a, vld_b;

  int compared = 0, mismatched = 0, cyc = 0;
  int cfg_p = 40, cfg_hi = 20, cfg_d = 0;
  bit cfg_sf = 1'b0, gen_on = 1'b0;

  // columns: period, high time, lag in clocks, signal-first, window, expected, tag code
  localparam int NV = 13;
  localparam int VEC [NV][7] = '{
    '{40, 20, 10, 0, 10,  -9000, 8},
    '{40, 20, 10, 1, 10,   9000, 8},
    '{40, 20, 25, 0,  4,  13500, 4},
    '{40, 20, 25, 1,  4, -13500, 4},
    '{40,  5, 10, 0,  3,  -9000, 5},
    '{40, 35, 10, 0,  3,  -9000, 5},
    '{48, 24,  0, 0,  2,      0, 1},
    '{48, 24,  4, 1,  2,   3000, 1},
    '{80, 40,  1, 0,  1,   -450, 3},
    '{60, 30, 29, 1,  5,  17400, 4},
    '{60, 30, 31, 1,  5, -17400, 4},
    '{70, 35,  1, 0,  3,   -514, 3},
    '{40, 20, 10, 0,  0,  -9000, 2}
  };

  pfd_phase_meter uut (
    .clk(clk), .rst(rst), .sig_sq(sig_sq), .ref_sq(ref_sq),
    .win_len(win_len), .phase_cdeg(ph_a), .phase_valid(vld_a)
  );

  pfd_phase_meter #(.CNT_W(10)) uut_sat (
    .clk(clk), .rst(rst), .sig_sq(sig_sq), .ref_sq(ref_sq),
    .win_len(win_len), .phase_cdeg(ph_b), .phase_valid(vld_b)
  );

  initial forever #2 clk = ~clk;
  initial forever begin @(posedge clk); cyc++; end

  // square-wave pair: the leading wave starts at t=0, the other d clocks later
  initial begin
    int t;
    logic lead, lag;
    t = 0;
    forever begin
      @(negedge clk);
      if (!gen_on) begin
        t = 0; sig_sq = 1'b0; ref_sq = 1'b0;
      end else begin
        lead = (t % cfg_p) < cfg_hi;
        lag  = (t >= cfg_d) && (((t - cfg_d) % cfg_p) < cfg_hi);
        if (cfg_sf) begin sig_sq = lead; ref_sq = lag; end
        else        begin ref_sq = lead; sig_sq = lag; end
        t++;
      end
    end
  end

  function automatic string tag_of(input int c);
    case (c)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_strobe(input bit which, output int stamp);
    int n;
    n = 0;
    stamp = -1;
    while (n < 20000) begin
      @(negedge clk);
      if ((which ? vld_b : vld_a) === 1'b1) begin
        stamp = cyc;
        break;
      end
      n++;
    end
    if (stamp < 0) begin
      compared++;
      mismatched++;
      $display("FAIL R2 strobe timeout actual=none expected=strobe");
    end
  endtask

  task automatic restart(input int p, input int hi, input int d, input int sf, input int n);
    gen_on = 1'b0;
    rst = 1'b1;
    cfg_p = p; cfg_hi = hi; cfg_d = d; cfg_sf = (sf != 0);
    win_len = n[7:0];
    repeat (4) @(negedge clk);
    rst = 1'b0;
    gen_on = 1'b1;
  endtask

  initial begin
    int s1, s2, s3, eff;
    // R7: reset state, and R2: no strobe without reference edges
    rst = 1'b1;
    repeat (5) @(negedge clk);
    check("R7 reset phase", int'(ph_a), 0);
    check("R7 reset strobe", int'(vld_a), 0);
    rst = 1'b0;
    repeat (30) @(negedge clk);
    check("R2 idle no strobe", int'(vld_a), 0);

    for (int i = 0; i < NV; i++) begin
      restart(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]);
      wait_strobe(1'b0, s1);
      wait_strobe(1'b0, s2);
      check(tag_of(VEC[i][6]), int'(ph_a), VEC[i][5]);
      @(negedge clk);
      check("R7 one-cycle strobe", int'(vld_a), 0);
      check("R7 phase held", int'(ph_a), VEC[i][5]);
      wait_strobe(1'b0, s3);
      eff = (VEC[i][4] == 0) ? 1 : VEC[i][4];
      check("R2 strobe spacing", s3 - s2, eff * VEC[i][0]);
    end

    // R6: counters saturate in the narrow instance; R4: fold in the wide one
    restart(40, 20, 30, 0, 40);
    wait_strobe(1'b1, s1);
    wait_strobe(1'b1, s2);
    check("R6 saturated phase", int'(ph_b), 1408);
    wait_strobe(1'b0, s3);
    check("R4 folded phase", int'(ph_a), 9000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule